// File: doc/BRIEF.md
# Bus Wait-State and Ready Controller

This block sets how long one bus cycle lasts. The bus sequencer pulses a start strobe and presents a 3-bit timing code, which comes from whichever chip-select region the address hit. The two low bits of the code give a fixed count of wait states, from 0 to 3. The top bit picks one of two modes. In fixed mode the external ready line is ignored and the cycle always lasts exactly the programmed count. In handshake mode the programmed count is a floor: after the count runs out, the cycle is held until the external ready line is seen high.

The external ready line is asynchronous. It passes through a two-flop synchronizer before the controller uses it. Each clock the block drives a wait flag, which the sequencer uses to insert a wait state. It ends the cycle with a one-clock done pulse. Devices that may need more than three wait states must use handshake mode, because only ready can stretch a cycle past three waits.

The controller is a three-state machine:
- `S_IDLE`: waits for a strobe. A strobe here latches the code and moves to `S_COUNT`.
- `S_COUNT`: counts the programmed waits down. When the count reaches zero, it raises done and returns to `S_IDLE` if the mode is fixed or the synchronized ready is high. Otherwise it moves to `S_AWAIT`.
- `S_AWAIT`: holds wait until the synchronized ready is high, then raises done and returns to `S_IDLE`.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While `rst` is high, and on every clock after it until the next accepted strobe, `wait_o` and `done_o` are low.
- R2: When bit 2 of the latched code is 1 (fixed mode), the cycle has exactly the programmed number of wait clocks, whatever level `ext_rdy` has.
- R3: Bits 1:0 of the latched code give N, the number of wait clocks inserted before done, from 0 to 3.
- R4: When bit 2 is 0 (handshake mode), done never comes before N wait clocks have passed, even if ready is high the whole time.
- R5: In handshake mode, once the count is exhausted, `wait_o` stays high until the synchronized ready is high. Done comes on the first clock where both hold.
- R6: `ext_rdy` reaches the controller through two flops. A rise of ready during the wait extension produces done on the second clock after it.
- R7: `done_o` is high for exactly one clock per cycle. `wait_o` and `done_o` are never high together.
- R8: The code is captured when the strobe is accepted. Changes on `timing_code` during the cycle have no effect on that cycle.
- R9: A strobe that arrives while a cycle is in progress is ignored and does not start a further cycle.
- R10: With N=0 in fixed mode, `done_o` is high on the clock right after the strobe, with no wait clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Bus-cycle start strobe, accepted when idle |
| timing_code | input | 3 | Bit 2: fixed mode; bits 1:0: wait count |
| ext_rdy | input | 1 | Asynchronous external ready |
| wait_o | output | 1 | High on each inserted wait clock |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
A wrong count value shows up at once as a cycle with too many or too few wait clocks, measured from the strobe to the done pulse. A wrong mode latch shows as a fixed-mode cycle that hangs while ready is low, or a handshake cycle that ends without ready. A state left stuck in `S_AWAIT` or `S_COUNT` shows as wait staying high, or as done repeating on the clock after it. A skipped or extra synchronizer stage moves the done pulse one clock away from the second clock after ready rises.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_AWAIT = 2'd2
    } bwc_state_t;
endpackage

// File: rtl/bwc_ready_sync.sv
module bwc_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bwc_wait_counter.sv
module bwc_wait_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        dec |-> !zero)
        else $error("counter decremented below zero");
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int CODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic [CODE_W-1:0] timing_code,
    input  logic              ext_rdy,
    output logic              wait_o,
    output logic              done_o
);
    localparam int CNT_W = CODE_W - 1;

    bwc_state_t st, nxt;
    logic       ign_q;
    logic       rdy_s;
    logic       cnt_zero;
    logic       take;
    logic       dec;

    bwc_ready_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ext_rdy),
        .q_sync  (rdy_s)
    );

    assign take = (st == S_IDLE) && cyc_start;
    assign dec  = (st == S_COUNT) && !cnt_zero;

    bwc_wait_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .load_val (timing_code[CNT_W-1:0]),
        .dec      (dec),
        .zero     (cnt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst)       ign_q <= 1'b0;
        else if (take) ign_q <= timing_code[CODE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (cyc_start) nxt = S_COUNT;
            S_COUNT: if (cnt_zero) nxt = (ign_q || rdy_s) ? S_IDLE : S_AWAIT;
            S_AWAIT: if (rdy_s) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        wait_o = 1'b0;
        done_o = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_COUNT: begin
                if (!cnt_zero)            wait_o = 1'b1;
                else if (ign_q || rdy_s)  done_o = 1'b1;
                else                      wait_o = 1'b1;
            end
            S_AWAIT: begin
                if (rdy_s) done_o = 1'b1;
                else       wait_o = 1'b1;
            end
            default: ;
        endcase
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> (!wait_o && !done_o))
        else $error("outputs active while idle");

    p_fixed_no_stretch_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_AWAIT) |-> !ign_q)
        else $error("fixed-mode cycle entered ready extension");

    p_count_floor_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> cnt_zero)
        else $error("done before wait count expired");

    p_rdy_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ign_q) |-> rdy_s)
        else $error("handshake cycle ended without ready");

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o)
        else $error("done longer than one clock");

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(wait_o && done_o))
        else $error("wait and done together");

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ((st != S_IDLE) && ($past(st) != S_IDLE)) |-> $stable(ign_q))
        else $error("mode changed mid-cycle");
endmodule

// File: tb/test_bus_wait_ctrl.sv
module test_bus_wait_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic [2:0] timing_code = 3'b000;
    logic       ext_rdy = 1'b0;
    logic       wait_o, done_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_wait_ctrl i_bus_wait_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cyc_start   (cyc_start),
        .timing_code (timing_code),
        .ext_rdy     (ext_rdy),
        .wait_o      (wait_o),
        .done_o      (done_o)
    );

    // entry: {code[2:0], rdy, expected waits[2:0]}
    localparam logic [6:0] VEC [8] = '{
        {3'b100, 1'b0, 3'd0},
        {3'b101, 1'b1, 3'd1},
        {3'b111, 1'b0, 3'd3},
        {3'b110, 1'b1, 3'd2},
        {3'b000, 1'b1, 3'd0},
        {3'b001, 1'b1, 3'd1},
        {3'b011, 1'b1, 3'd3},
        {3'b010, 1'b1, 3'd2}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] code);
        @(negedge clk);
        timing_code = code;
        cyc_start   = 1'b1;
        @(negedge clk);
        cyc_start   = 1'b0;
    endtask

    task automatic count_waits(output int n);
        n = 0;
        while (wait_o && !done_o && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!wait_o && !done_o, "R1 in reset", {wait_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!wait_o && !done_o, "R1 after reset", {wait_o, done_o}, 0);

        // table of patterns: R2 R3 R4 R10
        for (int i = 0; i < 8; i++) begin
            ext_rdy = VEC[i][3];
            repeat (4) @(negedge clk);
            strobe(VEC[i][6:4]);
            count_waits(n);
            check(done_o && n == int'(VEC[i][2:0]),
                  VEC[i][6] ? "R2 R3 R10 fixed count" : "R4 handshake floor",
                  n, int'(VEC[i][2:0]));
            @(negedge clk);
            check(!done_o && !wait_o, "R7 single done", {wait_o, done_o}, 0);
        end

        // R5 R6: extension by ready
        ext_rdy = 1'b0;
        repeat (4) @(negedge clk);
        strobe(3'b010);
        count_waits(n);
        check(n == 40 && wait_o && !done_o, "R5 held without ready", n, 40);
        ext_rdy = 1'b1;
        @(negedge clk);
        check(wait_o && !done_o, "R6 first sync stage", {wait_o, done_o}, 2);
        @(negedge clk);
        check(done_o && !wait_o, "R5 R6 done after sync", {wait_o, done_o}, 1);
        @(negedge clk);
        check(!done_o && !wait_o, "R7 idle after extension", {wait_o, done_o}, 0);

        // R2: fixed mode ignores low ready
        ext_rdy = 1'b0;
        repeat (4) @(negedge clk);
        strobe(3'b110);
        count_waits(n);
        check(done_o && n == 2, "R2 ready low ignored", n, 2);

        // R8: code change mid-cycle
        repeat (3) @(negedge clk);
        strobe(3'b101);
        timing_code = 3'b011;
        count_waits(n);
        check(done_o && n == 1, "R8 code latched", n, 1);

        // R9: second strobe during wait
        repeat (3) @(negedge clk);
        strobe(3'b111);
        cyc_start = 1'b1;
        timing_code = 3'b100;
        @(negedge clk);
        cyc_start = 1'b0;
        n = 1;
        while (wait_o && !done_o && n < 40) begin
            n++;
            @(negedge clk);
        end
        check(done_o && n == 3, "R9 busy strobe ignored", n, 3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!done_o && !wait_o, "R9 no retrigger", {wait_o, done_o}, 0);
        end

        // R1: reset during a cycle
        strobe(3'b111);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!wait_o && !done_o, "R1 reset aborts cycle", {wait_o, done_o}, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule